// File: doc/BRIEF.md
# Programmable LCD Panel Timing Generator

This block produces the line sync, frame sync and data-enable pins for a parallel RGB thin-film panel. It runs two position counters: one counts enabled pixel clocks across a line, the other counts lines across a frame. Software sets the line and frame lengths and four timing windows. Each window is one 32-bit word, with the first position in which the signal is active in the upper half and the first position in which it is inactive in the lower half. Each sync and enable pin has its own polarity control. Two more configuration bits are passed out as levels to the pad logic: one picks the pixel-clock edge and one inverts the data bus.

The counters move only in cycles where `pix_en_i` is high, so the system clock can run faster than the pixel rate. Writes land in a pending register set. That set is copied into the active set on the last pixel clock of a frame, so a frame is never built from a mix of old and new settings. Along with the pins, the block gives a pixel-request strobe for the data path and one-cycle start-of-frame and end-of-frame pulses. The panel cannot be paused, so the request strobe is a plain strobe with no ready input. The data source must deliver a pixel in every cycle that the strobe is high.

Top module: `lcd_timing_gen`

## Requirements
- R1: When reset is released, both position counters are 0 and the active set holds the timing given by the parameters. The default polarity is active-high, and the pixel-clock edge and data-inversion levels are 0.
- R2: The pixel counter advances only in a cycle with `pix_en_i` high. When it reaches line length minus 1 it returns to 0 and advances the line counter. The line counter returns to 0 after frame length minus 1.
- R3: Write addresses are: 0 line sync, 1 frame sync, 2 horizontal active, 3 vertical active, 4 lengths, 5 configuration. In each window word, bits [31:16] are the start and bits [15:0] are the end. The signal is active when start <= position < end. In the lengths word, bits [31:16] hold the line length and bits [15:0] hold the frame length.
- R4: The internal data-enable is the AND of the horizontal and vertical active windows, formed before polarity is applied.
- R5: Configuration bit 11 makes the line sync pin active-low, bit 8 makes the frame sync pin active-low, and bit 9 makes the data-enable pin active-low.
- R6: `pclk_fall_o` follows active configuration bit 10, and `data_inv_o` follows active configuration bit 17.
- R7: `pix_req_o` is high exactly when `pix_en_i` is high and the internal data-enable is true.
- R8: `sof_o` is high exactly when `pix_en_i` is high at line 0, pixel 0.
- R9: `eof_o` is high exactly when `pix_en_i` is high on the last pixel of the horizontal active window in the last line of the vertical active window. It never fires when either active window is empty.
- R10: A write changes only the pending set. The active set copies the pending set in the `pix_en_i` cycle in which both counters wrap. A write in that same cycle applies one frame later. Writes to addresses 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pix_en_i | input | 1 | Pixel clock enable; counters step when high |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 32 | Register write data |
| hsync_o | output | 1 | Line sync pin after polarity |
| vsync_o | output | 1 | Frame sync pin after polarity |
| de_o | output | 1 | Data-enable pin after polarity |
| pclk_fall_o | output | 1 | Selects the falling pixel-clock edge at the pad |
| data_inv_o | output | 1 | Inverts the data bus at the pad |
| pix_req_o | output | 1 | Pixel request strobe |
| sof_o | output | 1 | Start-of-frame pulse |
| eof_o | output | 1 | End-of-frame pulse |

## Verification
On every cycle, the assertions check that the pins and the active register set hold still while the pixel enable is low. They also check that the request and frame pulses only occur on enabled cycles, that a request always coincides with an asserted enable pin, and that end-of-frame falls inside the active area. The placement of each window, the wrap points, the polarity mapping and the deferral of a mid-frame write to the next frame boundary can only be shown by the bench's scenarios. The bench compares every pin on every cycle against its own arithmetic position model across several timing sets and enable patterns.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int unsigned TG_DW   = 32;
  localparam int unsigned TG_CW   = 16;
  localparam int unsigned TG_AW   = 3;
  localparam int unsigned TG_NREG = 6;

  // register indices
  localparam int unsigned RG_HSYNC = 0;
  localparam int unsigned RG_VSYNC = 1;
  localparam int unsigned RG_HACT  = 2;
  localparam int unsigned RG_VACT  = 3;
  localparam int unsigned RG_TOTAL = 4;
  localparam int unsigned RG_CFG   = 5;

  // configuration bit positions
  localparam int unsigned CB_VS_LOW  = 8;
  localparam int unsigned CB_DE_LOW  = 9;
  localparam int unsigned CB_PCLK_FE = 10;
  localparam int unsigned CB_HS_LOW  = 11;
  localparam int unsigned CB_DINV    = 17;

  typedef struct packed {
    logic [TG_CW-1:0] first;
    logic [TG_CW-1:0] last_excl;
  } tg_win_t;
endpackage

// File: rtl/lcd_tg_axis_cnt.sv
module lcd_tg_axis_cnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [CW-1:0] length_i,
  output logic [CW-1:0] pos_o,
  output logic          wrap_o
);
  localparam int unsigned XW = CW + 1;

  logic [XW-1:0] pos_next;

  assign pos_next = XW'(pos_o) + XW'(1);
  assign wrap_o   = step_i && (pos_next >= XW'(length_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o <= '0;
    end else if (wrap_o) begin
      pos_o <= '0;
    end else if (step_i) begin
      pos_o <= pos_o + CW'(1);
    end
  end
endmodule

// File: rtl/lcd_tg_win.sv
module lcd_tg_win #(
  parameter int unsigned CW = 16
) (
  input  logic          [CW-1:0] pos_i,
  input  lcd_tg_pkg::tg_win_t    win_i,
  input  logic                   low_i,
  output logic                   raw_o,
  output logic                   pin_o
);
  assign raw_o = (pos_i >= win_i.first) && (pos_i < win_i.last_excl);
  assign pin_o = raw_o ^ low_i;
endmodule

// File: rtl/lcd_tg_cfg.sv
module lcd_tg_cfg #(
  parameter int unsigned NREG = 6,
  parameter int unsigned AW   = 3,
  parameter int unsigned DW   = 32,
  parameter logic [NREG*DW-1:0] DEFAULTS = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               commit_i,
  output logic [NREG*DW-1:0] act_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_word
    logic [DW-1:0] pend_q;
    logic          hit;

    assign hit = we_i && (addr_i == AW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q              <= DEFAULTS[g*DW +: DW];
        act_o[g*DW +: DW]   <= DEFAULTS[g*DW +: DW];
      end else begin
        if (hit) pend_q <= wdata_i;
        if (commit_i) act_o[g*DW +: DW] <= pend_q;
      end
    end
  end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int unsigned H_VIS = 8,
  parameter int unsigned H_SW  = 2,
  parameter int unsigned H_BP  = 3,
  parameter int unsigned H_FP  = 2,
  parameter int unsigned V_VIS = 4,
  parameter int unsigned V_SW  = 1,
  parameter int unsigned V_BP  = 2,
  parameter int unsigned V_FP  = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pix_en_i,
  input  logic        cfg_we_i,
  input  logic [2:0]  cfg_addr_i,
  input  logic [31:0] cfg_wdata_i,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        de_o,
  output logic        pclk_fall_o,
  output logic        data_inv_o,
  output logic        pix_req_o,
  output logic        sof_o,
  output logic        eof_o
);
  import lcd_tg_pkg::*;

  localparam int unsigned CW = TG_CW;
  localparam int unsigned DW = TG_DW;
  localparam int unsigned XW = CW + 1;

  localparam logic [CW-1:0] H_ACT_A = CW'(H_SW + H_BP);
  localparam logic [CW-1:0] H_ACT_B = CW'(H_SW + H_BP + H_VIS);
  localparam logic [CW-1:0] H_LEN   = CW'(H_SW + H_BP + H_VIS + H_FP);
  localparam logic [CW-1:0] V_ACT_A = CW'(V_SW + V_BP);
  localparam logic [CW-1:0] V_ACT_B = CW'(V_SW + V_BP + V_VIS);
  localparam logic [CW-1:0] V_LEN   = CW'(V_SW + V_BP + V_VIS + V_FP);

  localparam logic [TG_NREG*DW-1:0] DEFAULTS = {
    32'h0,                         // configuration
    {H_LEN, V_LEN},                // lengths
    {V_ACT_A, V_ACT_B},            // vertical active
    {H_ACT_A, H_ACT_B},            // horizontal active
    {CW'(0), CW'(V_SW)},           // frame sync
    {CW'(0), CW'(H_SW)}            // line sync
  };

  logic [TG_NREG*DW-1:0] act_flat;
  logic [DW-1:0]         act_cfg;
  tg_win_t               act_len;
  logic [CW-1:0]         h_pos, v_pos;
  logic                  h_wrap, v_wrap;
  logic [3:0]            win_raw, win_pin, win_low;
  logic                  de_raw;

  assign act_cfg = act_flat[RG_CFG*DW +: DW];
  assign act_len = tg_win_t'(act_flat[RG_TOTAL*DW +: DW]);

  lcd_tg_cfg #(
    .NREG(TG_NREG), .AW(TG_AW), .DW(DW), .DEFAULTS(DEFAULTS)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .commit_i (v_wrap),
    .act_o    (act_flat)
  );

  lcd_tg_axis_cnt #(.CW(CW)) u_hcnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (pix_en_i),
    .length_i (act_len.first),
    .pos_o    (h_pos),
    .wrap_o   (h_wrap)
  );

  lcd_tg_axis_cnt #(.CW(CW)) u_vcnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (h_wrap),
    .length_i (act_len.last_excl),
    .pos_o    (v_pos),
    .wrap_o   (v_wrap)
  );

  // window 0: line sync, 1: frame sync, 2: horizontal active, 3: vertical active
  assign win_low = {1'b0, 1'b0, act_cfg[CB_VS_LOW], act_cfg[CB_HS_LOW]};

  for (genvar g = 0; g < 4; g++) begin : g_win
    localparam bit IS_VERT = (g % 2) == 1;
    lcd_tg_win #(.CW(CW)) u_win (
      .pos_i (IS_VERT ? v_pos : h_pos),
      .win_i (tg_win_t'(act_flat[g*DW +: DW])),
      .low_i (win_low[g]),
      .raw_o (win_raw[g]),
      .pin_o (win_pin[g])
    );
  end

  assign de_raw      = win_raw[RG_HACT] & win_raw[RG_VACT];
  assign hsync_o     = win_pin[RG_HSYNC];
  assign vsync_o     = win_pin[RG_VSYNC];
  assign de_o        = de_raw ^ act_cfg[CB_DE_LOW];
  assign pclk_fall_o = act_cfg[CB_PCLK_FE];
  assign data_inv_o  = act_cfg[CB_DINV];
  assign pix_req_o   = pix_en_i & de_raw;
  assign sof_o       = pix_en_i && (h_pos == '0) && (v_pos == '0);
  assign eof_o       = pix_req_o
                    && ((XW'(h_pos) + XW'(1)) == XW'(act_flat[RG_HACT*DW +: CW]))
                    && ((XW'(v_pos) + XW'(1)) == XW'(act_flat[RG_VACT*DW +: CW]));
endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         pix_en_i,
  input logic         hsync_o,
  input logic         vsync_o,
  input logic         de_o,
  input logic         pix_req_o,
  input logic         sof_o,
  input logic         eof_o,
  input logic [31:0]  act_cfg,
  input logic [191:0] act_flat
);
  assert_sof_enabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> pix_en_i);

  assert_req_enabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_req_o |-> pix_en_i);

  assert_req_pin_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_req_o |-> (de_o != act_cfg[9]));

  assert_eof_active_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> pix_req_o);

  assert_pins_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> $stable({hsync_o, vsync_o, de_o}));

  assert_active_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> $stable(act_flat));
endmodule

bind lcd_timing_gen lcd_timing_gen_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pix_en_i  (pix_en_i),
  .hsync_o   (hsync_o),
  .vsync_o   (vsync_o),
  .de_o      (de_o),
  .pix_req_o (pix_req_o),
  .sof_o     (sof_o),
  .eof_o     (eof_o),
  .act_cfg   (act_cfg),
  .act_flat  (act_flat)
);

// File: tb/lcd_timing_gen_test.sv
module lcd_timing_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pe = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic hs, vs, de, pfe, dinv, req, sof, eof;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  logic [31:0] pend [6];
  logic [31:0] act  [6];
  int h = 0;
  int v = 0;

  always #5 clk = ~clk;

  lcd_timing_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .pix_en_i(pe),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .hsync_o(hs), .vsync_o(vs), .de_o(de), .pclk_fall_o(pfe),
    .data_inv_o(dinv), .pix_req_o(req), .sof_o(sof), .eof_o(eof)
  );

  task automatic chk(input string tag, input logic act_v, input logic exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s at h=%0d v=%0d: got %b expected %b", tag, h, v, act_v, exp_v);
    end
  endtask

  function automatic bit inwin(input int pos, input logic [31:0] w);
    return (pos >= int'(w[31:16])) && (pos < int'(w[15:0]));
  endfunction

  // one cycle: drive at negedge, compare, then advance the model across the posedge
  task automatic step(input logic p, input logic w, input logic [2:0] a, input logic [31:0] d);
    bit hr, vr, har, var_, der, last_h, last_v;
    @(negedge clk);
    pe = p; we = w; addr = a; wdata = d;
    #1;
    hr   = inwin(h, act[0]);
    vr   = inwin(v, act[1]);
    har  = inwin(h, act[2]);
    var_ = inwin(v, act[3]);
    der  = har && var_;
    chk("R3 R5 hsync", hs, hr ^ act[5][11]);
    chk("R3 R5 vsync", vs, vr ^ act[5][8]);
    chk("R4 R5 de", de, der ^ act[5][9]);
    chk("R6 pclk_fall", pfe, act[5][10]);
    chk("R6 data_inv", dinv, act[5][17]);
    chk("R7 pix_req", req, p && der);
    chk("R2 R8 sof", sof, p && h == 0 && v == 0);
    chk("R9 eof", eof, p && der && (h + 1 == int'(act[2][15:0])) && (v + 1 == int'(act[3][15:0])));
    if (p) begin
      last_h = (h + 1 >= int'(act[4][31:16]));
      if (last_h) begin
        h = 0;
        last_v = (v + 1 >= int'(act[4][15:0]));
        if (last_v) begin
          v = 0;
          for (int i = 0; i < 6; i++) act[i] = pend[i];
        end else v++;
      end else h++;
    end
    if (w && a < 3'd6) pend[a] = d;
  endtask

  task automatic idle_run(input int n, input int gap);
    for (int i = 0; i < n; i++)
      step((gap == 0) || (i % gap != 0), 1'b0, 3'd0, 32'h0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R2: got hung run, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // defaults: line 15, frame 8
    pend[0] = {16'd0, 16'd2};  pend[1] = {16'd0, 16'd1};
    pend[2] = {16'd5, 16'd13}; pend[3] = {16'd3, 16'd7};
    pend[4] = {16'd15, 16'd8}; pend[5] = 32'h0;
    for (int i = 0; i < 6; i++) act[i] = pend[i];

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1: reset state at position 0,0 with default timing
    chk("R1 hsync after reset", hs, 1'b1);
    chk("R1 vsync after reset", vs, 1'b1);
    chk("R1 de after reset", de, 1'b0);
    chk("R1 data_inv after reset", dinv, 1'b0);

    // continuous enable, two frames
    idle_run(240, 0);
    // gapped enable, one frame and a half
    idle_run(270, 3);

    // mid-frame reprogramming with all polarity bits and ignored addresses
    idle_run(37, 0);
    step(1'b1, 1'b1, 3'd0, {16'd1, 16'd4});
    step(1'b1, 1'b1, 3'd1, {16'd0, 16'd2});
    step(1'b0, 1'b1, 3'd2, {16'd5, 16'd11});
    step(1'b1, 1'b1, 3'd3, {16'd3, 16'd6});
    step(1'b1, 1'b1, 3'd4, {16'd13, 16'd7});
    step(1'b1, 1'b1, 3'd5, 32'h0002_0F00);
    step(1'b1, 1'b1, 3'd6, 32'hFFFF_FFFF);
    step(1'b1, 1'b1, 3'd7, 32'hFFFF_FFFF);
    // R10: configuration not yet applied mid-frame
    #1;
    chk("R10 data_inv before boundary", dinv, 1'b0);
    chk("R10 pclk_fall before boundary", pfe, 1'b0);
    idle_run(300, 0);
    chk("R10 data_inv after boundary", dinv, 1'b1);
    idle_run(200, 4);

    // empty horizontal active window, one-line vertical window
    step(1'b1, 1'b1, 3'd2, {16'd6, 16'd6});
    step(1'b1, 1'b1, 3'd3, {16'd0, 16'd1});
    step(1'b1, 1'b1, 3'd5, 32'h0);
    idle_run(200, 0);
    // single-pixel active area at the last position of the frame
    step(1'b1, 1'b1, 3'd2, {16'd12, 16'd13});
    step(1'b1, 1'b1, 3'd3, {16'd6, 16'd7});
    idle_run(200, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule